// File: doc/BRIEF.md
# Paged DMA Address Extension Unit

This unit builds the full 32-bit bus address for each of eight DMA channels. Each channel's address counter supplies a 16-bit current address. The unit holds two 8-bit page registers per channel, a low page and a high page, and joins them with that address. Byte channels (0 to 3) place the counter directly in the bottom 16 bits. Word channels (4 to 7) shift the counter up one bit, force bit 0 to zero, and so ignore bit 0 of the low page. On word channels the low page therefore names 128K pages.

Software programs the pages through a byte-wide write port. A write to the low page disarms boundary crossing for that channel. A later write to the high page arms it. While a channel is armed, a carry out of its 16-bit counter moves the combined page {high, low} up by one page, and a borrow moves it down by one page. When the channel is not armed, the page stays fixed and the counter wraps inside its page. The address of the channel chosen by `out_ch` is presented on `phys_addr`.

Top module: `paged_addr_ext`

## Requirements
- R1: On a byte channel (0 to 3), `phys_addr[15:0]` equals that channel's 16-bit address and `phys_addr[23:16]` equals its low page.
- R2: On a word channel (4 to 7), `phys_addr[16:1]` equals the channel address, `phys_addr[23:17]` equals low page bits 7..1, and `phys_addr[0]` is 0. Low page bit 0 has no effect on the address.
- R3: `phys_addr[31:24]` equals the selected channel's high page on every channel.
- R4: A write with `wr_hi`=0 loads the low page of channel `wr_ch` and disarms its boundary crossing. A write with `wr_hi`=1 loads the high page and arms it. Both take effect at the clock edge where `wr_en` is 1.
- R5: A carry on an armed channel raises the 16-bit page value {high, low} by 1 on byte channels and by 2 on word channels, so that one 128K page is stepped. The rise carries into the high page, and the value wraps from all-ones to zero.
- R6: A borrow on an armed channel lowers the page value by the same step, and the value wraps from zero to all-ones.
- R7: On a disarmed channel, carry and borrow leave the page registers unchanged.
- R8: A cycle with both carry and borrow on one channel leaves its page unchanged. A register write to a channel in the same cycle as its carry or borrow takes precedence, and the carry or borrow is dropped.
- R9: While `rst_n` is 0 at a clock edge, every page register is cleared to zero and every channel is disarmed.
- R10: Writes, carries and borrows affect only the addressed channel. `out_ch` selects which channel drives `phys_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Page register write strobe |
| wr_hi | input | 1 | 0 selects the low page, 1 selects the high page |
| wr_ch | input | 3 | Channel addressed by the write |
| wr_data | input | 8 | Write data |
| ch_addr | input | 128 | Current 16-bit address of each channel; channel n occupies bits 16n+15..16n |
| cnt_carry | input | 8 | Per-channel carry out of the address counter |
| cnt_borrow | input | 8 | Per-channel borrow out of the address counter |
| out_ch | input | 3 | Channel whose address is shown |
| phys_addr | output | 32 | Physical address of channel `out_ch` |

## Verification
The bench steps the page value across the low-to-high boundary and wraps it at both ends. A design that carries only within the low page would show a stuck high page, and one without wrap would leave stray bits. Word channels are driven with low page bit 0 set and a two-step page increment. A design that keeps bit 0, or steps by one, would produce odd pages or addresses. The bench also applies a carry after a low-page write, carry and borrow together, and a write in the same cycle as a carry. A design with the wrong arming or precedence would move the page in any of these cases. A reset in the middle of the run must leave a channel both cleared and disarmed.

// File: rtl/pax_pkg.sv
// Shared constants and helpers for the paged address extension unit.
// Assumes channels numbered from WORD_FIRST upward run in word mode.
package pax_pkg;
    localparam int NUM_CH     = 8;
    localparam int CNT_W      = 16;
    localparam int PAGE_W     = 8;
    localparam int HI_W       = 8;
    localparam int WORD_FIRST = 4;
    localparam int PG_W       = HI_W + PAGE_W;
    localparam int PA_W       = HI_W + PAGE_W + CNT_W;

    // Word mode decision for a given channel number.
    function automatic bit is_word_ch(input int ch);
        return ch >= WORD_FIRST;
    endfunction
endpackage

// File: rtl/pax_page_chan.sv
// Page state for one channel: low page, high page and boundary-crossing arm.
// Assumes writes take priority over carry/borrow in the same cycle and that
// simultaneous carry and borrow cancel. Word channels step by two so that
// low page bit 0 is never disturbed.
module pax_page_chan #(
    parameter int PAGE_W  = 8,
    parameter int HI_W    = 8,
    parameter bit IS_WORD = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_lo,
    input  logic                     wr_hi,
    input  logic [PAGE_W-1:0]        wr_data,
    input  logic                     carry,
    input  logic                     borrow,
    output logic [HI_W+PAGE_W-1:0]   page,
    output logic                     armed
);
    localparam int PG_W = HI_W + PAGE_W;
    localparam logic [PG_W-1:0] STEP = IS_WORD ? PG_W'(2) : PG_W'(1);

    logic [PAGE_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    logic              arm_q;
    logic [PG_W-1:0]   stepped;
    logic              do_step;

    // Next page value when the counter over- or underflows.
    always_comb begin
        do_step = arm_q && (carry ^ borrow);
        stepped = carry ? ({hi_q, lo_q} + STEP) : ({hi_q, lo_q} - STEP);
    end

    // Register update: reset, then writes, then page stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            arm_q <= 1'b0;
        end else if (wr_lo) begin
            lo_q  <= wr_data;
            arm_q <= 1'b0;
        end else if (wr_hi) begin
            hi_q  <= HI_W'(wr_data);
            arm_q <= 1'b1;
        end else if (do_step) begin
            {hi_q, lo_q} <= stepped;
        end
    end

    assign page  = {hi_q, lo_q};
    assign armed = arm_q;
endmodule

// File: rtl/pax_addr_map.sv
// Joins a channel's page value with its 16-bit counter address.
// Byte variant: {high, low, addr}. Word variant: {high, low[7:1], addr, 0}.
module pax_addr_map #(
    parameter int CNT_W   = 16,
    parameter int PAGE_W  = 8,
    parameter int HI_W    = 8,
    parameter bit IS_WORD = 1'b0
) (
    input  logic [HI_W+PAGE_W-1:0]       page,
    input  logic [CNT_W-1:0]             addr,
    output logic [HI_W+PAGE_W+CNT_W-1:0] phys
);
    generate
        if (IS_WORD) begin : g_word
            // Counter moves up one bit; low page bit 0 is dropped.
            assign phys = {page[HI_W+PAGE_W-1:1], addr, 1'b0};
        end else begin : g_byte
            // Counter sits directly under the full page value.
            assign phys = {page, addr};
        end
    endgenerate
endmodule

// File: rtl/paged_addr_ext.sv
// Top of the paged DMA address extension unit. Decodes the byte write port
// into per-channel low/high page writes, keeps page state per channel, maps
// each channel to a 32-bit address and shows the channel chosen by out_ch.
// Assumes carry/borrow are one-cycle pulses from the external counter.
module paged_addr_ext
    import pax_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_hi,
    input  logic [2:0]                wr_ch,
    input  logic [PAGE_W-1:0]         wr_data,
    input  logic [NUM_CH*CNT_W-1:0]   ch_addr,
    input  logic [NUM_CH-1:0]         cnt_carry,
    input  logic [NUM_CH-1:0]         cnt_borrow,
    input  logic [2:0]                out_ch,
    output logic [PA_W-1:0]           phys_addr
);
    logic [NUM_CH*PG_W-1:0] page_flat;
    logic [NUM_CH-1:0]      xen_vec;
    logic [PA_W-1:0]        phys_arr [NUM_CH];

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic sel;
            // Write decode for this channel.
            assign sel = wr_en && (wr_ch == 3'(c));

            pax_page_chan #(
                .PAGE_W (PAGE_W),
                .HI_W   (HI_W),
                .IS_WORD(is_word_ch(c))
            ) u_pg (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_lo  (sel && !wr_hi),
                .wr_hi  (sel && wr_hi),
                .wr_data(wr_data),
                .carry  (cnt_carry[c]),
                .borrow (cnt_borrow[c]),
                .page   (page_flat[c*PG_W +: PG_W]),
                .armed  (xen_vec[c])
            );

            pax_addr_map #(
                .CNT_W  (CNT_W),
                .PAGE_W (PAGE_W),
                .HI_W   (HI_W),
                .IS_WORD(is_word_ch(c))
            ) u_map (
                .page(page_flat[c*PG_W +: PG_W]),
                .addr(ch_addr[c*CNT_W +: CNT_W]),
                .phys(phys_arr[c])
            );
        end
    endgenerate

    // Output selection of the observed channel.
    assign phys_addr = phys_arr[out_ch];
endmodule

// File: rtl/pax_checker.sv
// Property checker for paged_addr_ext; bound to every instance of the top.
module pax_checker
    import pax_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    wr_hi,
    input logic [2:0]              wr_ch,
    input logic [NUM_CH*CNT_W-1:0] ch_addr,
    input logic [2:0]              out_ch,
    input logic [PA_W-1:0]         phys_addr,
    input logic [NUM_CH*PG_W-1:0]  page_flat,
    input logic [NUM_CH-1:0]       xen_vec
);
    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> (page_flat == '0 && xen_vec == '0));

    assert_lo_write_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi) |=> !xen_vec[$past(wr_ch)]);

    assert_hi_write_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=> xen_vec[$past(wr_ch)]);

    assert_word_bit0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(out_ch) >= WORD_FIRST) |-> (phys_addr[0] == 1'b0));

    assert_byte_low_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(out_ch) < WORD_FIRST) |-> (phys_addr[CNT_W-1:0] == ch_addr[out_ch*CNT_W +: CNT_W]));

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_hold
            assert_disarmed_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (!xen_vec[c] && !(wr_en && wr_ch == 3'(c))) |=>
                    $stable(page_flat[c*PG_W +: PG_W]));
        end
    endgenerate
endmodule

bind paged_addr_ext pax_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_hi    (wr_hi),
    .wr_ch    (wr_ch),
    .ch_addr  (ch_addr),
    .out_ch   (out_ch),
    .phys_addr(phys_addr),
    .page_flat(page_flat),
    .xen_vec  (xen_vec)
);

// File: tb/paged_addr_ext_test.sv
module paged_addr_ext_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_hi = 1'b0;
    logic [2:0]   wr_ch = '0;
    logic [7:0]   wr_data = '0;
    logic [127:0] ch_addr = '0;
    logic [7:0]   cnt_carry = '0;
    logic [7:0]   cnt_borrow = '0;
    logic [2:0]   out_ch = '0;
    logic [31:0]  phys_addr;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    paged_addr_ext uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_ch(wr_ch),
        .wr_data(wr_data), .ch_addr(ch_addr), .cnt_carry(cnt_carry),
        .cnt_borrow(cnt_borrow), .out_ch(out_ch), .phys_addr(phys_addr)
    );

    // op codes: 0 low page write, 1 high page write, 2 carry, 3 borrow
    // vector layout: {op[1:0], ch[2:0], data[7:0], addr[15:0], expected[31:0]}
    localparam int NV = 19;
    localparam logic [60:0] VEC [NV] = '{
        {2'd0, 3'd0, 8'h12, 16'h3456, 32'hAB12_3456 & 32'h00FF_FFFF},
        {2'd1, 3'd0, 8'hAB, 16'h3456, 32'hAB12_3456},
        {2'd2, 3'd0, 8'h00, 16'h0000, 32'hAB13_0000},
        {2'd3, 3'd0, 8'h00, 16'hFFFF, 32'hAB12_FFFF},
        {2'd0, 3'd0, 8'hFF, 16'h0000, 32'hABFF_0000},
        {2'd2, 3'd0, 8'h00, 16'h0001, 32'hABFF_0001},
        {2'd1, 3'd0, 8'hAB, 16'h0000, 32'hABFF_0000},
        {2'd2, 3'd0, 8'h00, 16'h0000, 32'hAC00_0000},
        {2'd0, 3'd5, 8'h35, 16'h0001, 32'h0034_0002},
        {2'd1, 3'd5, 8'h01, 16'h0001, 32'h0134_0002},
        {2'd2, 3'd5, 8'h00, 16'h0000, 32'h0136_0000},
        {2'd3, 3'd5, 8'h00, 16'hFFFF, 32'h0135_FFFE},
        {2'd1, 3'd3, 8'hFF, 16'hFFFF, 32'hFF00_FFFF},
        {2'd2, 3'd3, 8'h00, 16'h0000, 32'hFF01_0000},
        {2'd0, 3'd3, 8'hFF, 16'h0000, 32'hFFFF_0000},
        {2'd1, 3'd3, 8'hFF, 16'h0000, 32'hFFFF_0000},
        {2'd2, 3'd3, 8'h00, 16'h0000, 32'h0000_0000},
        {2'd3, 3'd3, 8'h00, 16'hFFFF, 32'hFFFF_FFFF},
        {2'd3, 3'd7, 8'h00, 16'h1234, 32'h0000_2468}
    };
    localparam string TAG [NV] = '{
        "R1", "R3", "R5", "R6", "R4", "R7", "R4", "R5", "R2", "R3",
        "R5", "R6", "R3", "R5", "R4", "R4", "R5", "R6", "R7"
    };

    task automatic check(input string req, input logic [31:0] exp);
        total++;
        if (phys_addr !== exp) begin
            bad++;
            $display("FAIL %s ch=%0d actual=%08h expected=%08h", req, out_ch, phys_addr, exp);
        end
    endtask

    // Apply one operation for a single clock edge, then release it.
    task automatic apply(input logic [1:0] op, input logic [2:0] ch, input logic [7:0] d);
        @(negedge clk);
        case (op)
            2'd0: begin wr_en = 1'b1; wr_hi = 1'b0; wr_ch = ch; wr_data = d; end
            2'd1: begin wr_en = 1'b1; wr_hi = 1'b1; wr_ch = ch; wr_data = d; end
            2'd2: cnt_carry[ch] = 1'b1;
            default: cnt_borrow[ch] = 1'b1;
        endcase
        @(negedge clk);
        wr_en = 1'b0; wr_hi = 1'b0; cnt_carry = '0; cnt_borrow = '0;
    endtask

    task automatic look(input logic [2:0] ch, input logic [15:0] a);
        out_ch = ch;
        ch_addr[ch*16 +: 16] = a;
        #2;
    endtask

    initial begin
        #4_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state is all-zero page on every channel
        look(3'd1, 16'h0000);
        check("R9", 32'h0000_0000);
        look(3'd6, 16'h0000);
        check("R9", 32'h0000_0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][60:59], VEC[i][58:56], VEC[i][55:48]);
            look(VEC[i][58:56], VEC[i][47:32]);
            check(TAG[i], VEC[i][31:0]);
        end

        // R10: channel 0 untouched by later traffic on 3, 5 and 7
        look(3'd0, 16'h0000);
        check("R10", 32'hAC00_0000);
        // R10: channel 1 untouched by all traffic
        look(3'd1, 16'h4321);
        check("R10", 32'h0000_4321);

        // R8: carry and borrow together on armed channel 0
        @(negedge clk);
        cnt_carry[0] = 1'b1; cnt_borrow[0] = 1'b1;
        @(negedge clk);
        cnt_carry = '0; cnt_borrow = '0;
        look(3'd0, 16'h0000);
        check("R8", 32'hAC00_0000);

        // R8: low page write and carry in the same cycle: write wins
        @(negedge clk);
        wr_en = 1'b1; wr_hi = 1'b0; wr_ch = 3'd0; wr_data = 8'h55; cnt_carry[0] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cnt_carry = '0;
        look(3'd0, 16'h0000);
        check("R8", 32'hAC55_0000);
        // R7: that write disarmed channel 0, so a carry is ignored
        apply(2'd2, 3'd0, 8'h00);
        look(3'd0, 16'h0000);
        check("R7", 32'hAC55_0000);

        // R2: word channel with low page bit 0 set and armed, carry steps 128K
        apply(2'd0, 3'd4, 8'h01);
        apply(2'd1, 3'd4, 8'h00);
        apply(2'd2, 3'd4, 8'h00);
        look(3'd4, 16'h8000);
        check("R2", 32'h0003_0000);

        // R9: reset in mid run clears page and disarms channel 5
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(3'd5, 16'h0000);
        check("R9", 32'h0000_0000);
        apply(2'd2, 3'd5, 8'h00);
        look(3'd5, 16'h0000);
        check("R9", 32'h0000_0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule